// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Sequencer

The block is the command engine of one DMA channel. Software places a chain of 16-byte descriptors in memory, loads the channel's command pointer, and sets the run and active bits of the status register. The channel then fetches one descriptor at a time over its memory port and executes it. A command can hand a buffer to a device-side data mover, copy a word between memory and the descriptor, do nothing, or stop the chain. Each command carries three 2-bit condition selectors that decide whether completion stalls, whether an interrupt is raised and whether the chain branches.

A transfer command starts the device with an address, a length, a direction and a last flag. The channel then stays in a processing state while the device reports chunks, and it leaves that state only when the device pulses done. Completion then runs as a fixed sequence: the wait check, the write of status and residual count into the descriptor, the interrupt, and the pointer update. A malformed command kills the channel. It sets the dead bit and clears the active bit, and no device start takes place.

Descriptor layout, as byte offsets from the command pointer:
- +0 holds the command word. Bits 31:16 are the request count. Bits 15:12 are the opcode. Bits 10:8 are the key. Bits 5:4 select the interrupt condition, bits 3:2 the branch condition and bits 1:0 the wait condition.
- +4 holds the operand address.
- +8 holds the dependent word, which is the branch target or the load/store data.
- +12 receives the writeback: the status in bits 23:16 and the residual count in bits 15:0.

Opcodes are 0 output-more, 1 output-last, 2 input-more, 3 input-last, 4 store-word, 5 load-word, 6 no-op and 7 stop. Keys 0 to 3 are data streams, key 4 is invalid and key 6 is the system key.

The status bits are: bit 0 run, bit 1 active, bit 2 dead, bit 3 flush, bit 4 condition flag. Condition selectors are: 0 never, 1 if the flag is set, 2 if the flag is clear, 3 always.

Top module: `dma_seq_top`

## Requirements
- R1: After reset the status register and the command pointer are zero, and memReq, devBusy and irq are low.
- R2: A descriptor is fetched only while the channel is idle with run and active both set. After a control write that sets active, memReq rises one cycle after the write has taken effect, at address cmdPtr, and the words at +0, +4 and +8 are read in that order.
- R3: An opcode in 0 to 3 pulses devStart for one cycle. devIsOut is high for opcodes 0 and 1, and devIsLast is high for opcodes 1 and 3. devAddr and devLen then present the operand address and the request count. devBusy stays high until devDone, and no memory request is made while devBusy is high.
- R4: Each devChunk advances devAddr by devChunkLen and lowers devLen by devChunkLen. devLen stops at zero when a chunk exceeds what remains.
- R5: On completion the word {8'h00, status, residual} is written to cmdPtr+12. The residual is devLen at done for transfers and 0 for other commands. Flush is cleared after that write.
- R6: While the wait selector's condition holds, completion stalls: no writeback, interrupt or pointer change occurs until the condition clears.
- R7: After the writeback, irq pulses for exactly one cycle if the interrupt selector's condition holds.
- R8: For transfers and no-op, the command pointer becomes the dependent word when the branch condition holds. Otherwise it advances by 16.
- R9: The channel is killed and makes no device start, no writeback and no pointer change in these cases: a transfer with operand address 0, a transfer with a key above 3 (key 4 included), a load or store with a key other than 6, or an opcode above 7. Killed means dead set and active cleared.
- R10: Stop clears active, dead and flush, and leaves the command pointer and memory unchanged.
- R11: Load-word reads the word at the operand address, writes it to cmdPtr+8 and then writes back. It always advances the pointer by 16, whatever the branch selector says.
- R12: Store-word writes the dependent word to the operand address, then writes back and advances the pointer by 16.
- R13: No-op performs the writeback, interrupt and branch steps without touching the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Status register write strobe |
| ctrlMask | input | 8 | Bits of the status register to update |
| ctrlVal | input | 8 | New values for the masked status bits |
| ptrWe | input | 1 | Command pointer write strobe |
| ptrVal | input | 32 | New command pointer |
| status | output | 8 | Status register |
| cmdPtr | output | 32 | Current command pointer |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory request completed |
| devStart | output | 1 | One-cycle pulse starting a device transfer |
| devBusy | output | 1 | Channel is waiting for the device to finish |
| devIsOut | output | 1 | Transfer moves memory to the device |
| devIsLast | output | 1 | Transfer is the last of its packet |
| devAddr | output | 32 | Current transfer address |
| devLen | output | 16 | Remaining transfer length |
| devChunk | input | 1 | Device moved one chunk |
| devChunkLen | input | 16 | Byte count of that chunk |
| devDone | input | 1 | Device ended the transfer |
| irq | output | 1 | Interrupt pulse |

## Verification
The chains mix all eight opcodes. The device reports chunk patterns that end short of the request, so the residual is non-zero, and patterns that overshoot it, so the residual clamps to zero. The condition flag is run both set and clear, so that the "if set", "if clear", "always" and "never" selectors each change the outcome for interrupt, branch and wait. Malformed descriptors cover a zero address, key 4, and a non-system key on load. Each of them must kill the channel before any device start or memory write. A later stop must clear the dead state. A held wait condition must produce no writeback until the flag drops. Each descriptor write is matched against an ordered queue of expected addresses and data, so a wrong branch target or advance shows up as a mismatch.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int ADDR_W      = 32;
  localparam int WORD_W      = 32;
  localparam int LEN_W       = 16;
  localparam int STATUS_W    = 8;
  localparam int DESC_BYTES  = 16;
  localparam int FETCH_WORDS = 3;
  localparam int IDX_W       = $clog2(FETCH_WORDS);
  localparam int DEP_OFS     = 8;
  localparam int WB_OFS      = 12;

  localparam int ST_RUN    = 0;
  localparam int ST_ACTIVE = 1;
  localparam int ST_DEAD   = 2;
  localparam int ST_FLUSH  = 3;
  localparam int ST_COND   = 4;

  localparam logic [3:0] OP_OUT_MORE = 4'd0;
  localparam logic [3:0] OP_OUT_LAST = 4'd1;
  localparam logic [3:0] OP_IN_MORE  = 4'd2;
  localparam logic [3:0] OP_IN_LAST  = 4'd3;
  localparam logic [3:0] OP_STORE    = 4'd4;
  localparam logic [3:0] OP_LOAD     = 4'd5;
  localparam logic [3:0] OP_NOP      = 4'd6;
  localparam logic [3:0] OP_STOP     = 4'd7;

  localparam logic [2:0] KEY_LAST_STREAM = 3'd3;
  localparam logic [2:0] KEY_SYS         = 3'd6;

  typedef enum logic [2:0] {MS_FETCH, MS_OPND, MS_DEP, MS_WB, MS_STORE} memSel_t;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_XFER, S_LDRD, S_LDWR, S_STWR, S_WAIT, S_WB, S_FIN
  } seqState_t;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] capIdx;
    logic             startXfer;
    logic             kill;
    logic             stop;
    logic             writeDone;
    logic             advance;
    logic             branch;
    logic [IDX_W-1:0] fetchIdx;
    memSel_t          memSel;
  } strobes_t;

  function automatic logic condMet(input logic [1:0] sel, input logic flag);
    case (sel)
      2'd0:    return 1'b0;
      2'd1:    return flag;
      2'd2:    return !flag;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            st,
  input  logic                ctrlWe,
  input  logic [STATUS_W-1:0] ctrlMask,
  input  logic [STATUS_W-1:0] ctrlVal,
  input  logic                ptrWe,
  input  logic [ADDR_W-1:0]   ptrVal,
  input  logic [WORD_W-1:0]   memRdata,
  input  logic                devChunk,
  input  logic [LEN_W-1:0]    devChunkLen,
  output logic [STATUS_W-1:0] status,
  output logic [ADDR_W-1:0]   cmdPtr,
  output logic [WORD_W-1:0]   cmdWord,
  output logic [ADDR_W-1:0]   opAddr,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memWdata,
  output logic [ADDR_W-1:0]   devAddr,
  output logic [LEN_W-1:0]    devLen
);
  localparam int PAD_W = WORD_W - STATUS_W - LEN_W;

  logic [WORD_W-1:0]   descQ [FETCH_WORDS];
  logic [STATUS_W-1:0] statusQ, statusD;
  logic [ADDR_W-1:0]   cmdPtrQ;
  logic [ADDR_W-1:0]   xferAddrQ;
  logic [LEN_W-1:0]    xferLenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < FETCH_WORDS; w++) descQ[w] <= '0;
    end else if (st.capture) begin
      for (int w = 0; w < FETCH_WORDS; w++)
        if (int'(st.capIdx) == w) descQ[w] <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferAddrQ <= '0;
      xferLenQ  <= '0;
    end else if (st.startXfer) begin
      xferAddrQ <= descQ[1];
      xferLenQ  <= descQ[0][WORD_W-1 -: LEN_W];
    end else if (st.capture && st.capIdx == '0) begin
      xferLenQ  <= '0;
    end else if (devChunk) begin
      xferAddrQ <= xferAddrQ + ADDR_W'(devChunkLen);
      xferLenQ  <= (devChunkLen >= xferLenQ) ? '0 : xferLenQ - devChunkLen;
    end
  end

  always_comb begin
    statusD = statusQ;
    if (st.kill) begin
      statusD[ST_DEAD]   = 1'b1;
      statusD[ST_ACTIVE] = 1'b0;
    end
    if (st.stop) begin
      statusD[ST_ACTIVE] = 1'b0;
      statusD[ST_DEAD]   = 1'b0;
      statusD[ST_FLUSH]  = 1'b0;
    end
    if (st.writeDone) statusD[ST_FLUSH] = 1'b0;
    if (ctrlWe) statusD = (statusD & ~ctrlMask) | (ctrlVal & ctrlMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      cmdPtrQ <= '0;
    end else begin
      statusQ <= statusD;
      if (ptrWe)           cmdPtrQ <= ptrVal;
      else if (st.advance) cmdPtrQ <= st.branch ? descQ[2] : cmdPtrQ + ADDR_W'(DESC_BYTES);
    end
  end

  always_comb begin
    memWdata = '0;
    case (st.memSel)
      MS_FETCH: memAddr = cmdPtrQ + ADDR_W'({st.fetchIdx, 2'b00});
      MS_OPND:  memAddr = descQ[1];
      MS_DEP: begin
        memAddr  = cmdPtrQ + ADDR_W'(DEP_OFS);
        memWdata = descQ[2];
      end
      MS_WB: begin
        memAddr  = cmdPtrQ + ADDR_W'(WB_OFS);
        memWdata = {{PAD_W{1'b0}}, statusQ, xferLenQ};
      end
      MS_STORE: begin
        memAddr  = descQ[1];
        memWdata = descQ[2];
      end
      default:  memAddr = cmdPtrQ;
    endcase
  end

  assign status  = statusQ;
  assign cmdPtr  = cmdPtrQ;
  assign cmdWord = descQ[0];
  assign opAddr  = descQ[1];
  assign devAddr = xferAddrQ;
  assign devLen  = xferLenQ;
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] status,
  input  logic [WORD_W-1:0]   cmdWord,
  input  logic [ADDR_W-1:0]   opAddr,
  input  logic                memAck,
  input  logic                devDone,
  output strobes_t            st,
  output logic                memReq,
  output logic                memWe,
  output logic                devStart,
  output logic                devBusy,
  output logic                devIsOut,
  output logic                devIsLast,
  output logic                irq
);
  seqState_t        stateQ, stateD;
  logic [IDX_W-1:0] fetchCntQ, fetchCntD;

  logic [3:0] op;
  logic [2:0] key;
  logic [1:0] intSel, brSel, waitSel;
  logic       isXfer, isLdSt, flag;
  logic       unusedOk;

  assign op       = cmdWord[15:12];
  assign key      = cmdWord[10:8];
  assign intSel   = cmdWord[5:4];
  assign brSel    = cmdWord[3:2];
  assign waitSel  = cmdWord[1:0];
  assign isXfer   = (op <= OP_IN_LAST);
  assign isLdSt   = (op == OP_LOAD) || (op == OP_STORE);
  assign flag     = status[ST_COND];
  assign unusedOk = ^{cmdWord[WORD_W-1:16], cmdWord[11], cmdWord[7:6], status[STATUS_W-1:5], status[3:2]};

  assign devIsOut  = isXfer && (op[1] == 1'b0);
  assign devIsLast = isXfer && op[0];

  always_comb begin
    st        = '0;
    stateD    = stateQ;
    fetchCntD = fetchCntQ;
    memReq    = 1'b0;
    memWe     = 1'b0;
    devStart  = 1'b0;
    devBusy   = 1'b0;
    irq       = 1'b0;
    case (stateQ)
      S_IDLE:
        if (status[ST_RUN] && status[ST_ACTIVE]) begin
          stateD    = S_FETCH;
          fetchCntD = '0;
        end
      S_FETCH: begin
        memReq      = 1'b1;
        st.memSel   = MS_FETCH;
        st.fetchIdx = fetchCntQ;
        if (memAck) begin
          st.capture = 1'b1;
          st.capIdx  = fetchCntQ;
          if (int'(fetchCntQ) == FETCH_WORDS - 1) stateD = S_DECODE;
          else fetchCntD = fetchCntQ + 1'b1;
        end
      end
      S_DECODE: begin
        if (op == OP_NOP) begin
          stateD = S_WAIT;
        end else if (op == OP_STOP) begin
          st.stop = 1'b1;
          stateD  = S_IDLE;
        end else if (isXfer) begin
          if (key > KEY_LAST_STREAM || opAddr == '0) begin
            st.kill = 1'b1;
            stateD  = S_IDLE;
          end else begin
            st.startXfer = 1'b1;
            devStart     = 1'b1;
            stateD       = S_XFER;
          end
        end else if (isLdSt && key == KEY_SYS) begin
          stateD = (op == OP_LOAD) ? S_LDRD : S_STWR;
        end else begin
          st.kill = 1'b1;
          stateD  = S_IDLE;
        end
      end
      S_XFER: begin
        devBusy = 1'b1;
        if (devDone) stateD = S_WAIT;
      end
      S_LDRD: begin
        memReq    = 1'b1;
        st.memSel = MS_OPND;
        if (memAck) begin
          st.capture = 1'b1;
          st.capIdx  = IDX_W'(2);
          stateD     = S_LDWR;
        end
      end
      S_LDWR: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        st.memSel = MS_DEP;
        if (memAck) stateD = S_WAIT;
      end
      S_STWR: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        st.memSel = MS_STORE;
        if (memAck) stateD = S_WAIT;
      end
      S_WAIT:
        if (!condMet(waitSel, flag)) stateD = S_WB;
      S_WB: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        st.memSel = MS_WB;
        if (memAck) begin
          st.writeDone = 1'b1;
          stateD       = S_FIN;
        end
      end
      S_FIN: begin
        irq        = condMet(intSel, flag);
        st.advance = 1'b1;
        st.branch  = !isLdSt && condMet(brSel, flag);
        stateD     = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      fetchCntQ <= '0;
    end else begin
      stateQ    <= stateD;
      fetchCntQ <= fetchCntD;
    end
  end
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWe,
  input  logic [STATUS_W-1:0] ctrlMask,
  input  logic [STATUS_W-1:0] ctrlVal,
  input  logic                ptrWe,
  input  logic [ADDR_W-1:0]   ptrVal,
  output logic [STATUS_W-1:0] status,
  output logic [ADDR_W-1:0]   cmdPtr,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memWdata,
  input  logic [WORD_W-1:0]   memRdata,
  input  logic                memAck,
  output logic                devStart,
  output logic                devBusy,
  output logic                devIsOut,
  output logic                devIsLast,
  output logic [ADDR_W-1:0]   devAddr,
  output logic [LEN_W-1:0]    devLen,
  input  logic                devChunk,
  input  logic [LEN_W-1:0]    devChunkLen,
  input  logic                devDone,
  output logic                irq
);
  strobes_t          st;
  logic [WORD_W-1:0] cmdWord;
  logic [ADDR_W-1:0] opAddr;

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .status(status), .cmdWord(cmdWord), .opAddr(opAddr),
    .memAck(memAck), .devDone(devDone), .st(st), .memReq(memReq), .memWe(memWe),
    .devStart(devStart), .devBusy(devBusy), .devIsOut(devIsOut),
    .devIsLast(devIsLast), .irq(irq)
  );

  dma_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .ctrlWe(ctrlWe), .ctrlMask(ctrlMask),
    .ctrlVal(ctrlVal), .ptrWe(ptrWe), .ptrVal(ptrVal), .memRdata(memRdata),
    .devChunk(devChunk), .devChunkLen(devChunkLen), .status(status),
    .cmdPtr(cmdPtr), .cmdWord(cmdWord), .opAddr(opAddr), .memAddr(memAddr),
    .memWdata(memWdata), .devAddr(devAddr), .devLen(devLen)
  );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
  import dma_seq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                ctrlWe,
  input logic [STATUS_W-1:0] status,
  input logic                memReq,
  input logic                devStart,
  input logic                devBusy,
  input logic [LEN_W-1:0]    devLen,
  input logic                irq
);
  a_r3_no_mem_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    devBusy |-> !memReq);

  a_r3_start_enters_busy: assert property (@(posedge clk) disable iff (!rstN)
    devStart |=> devBusy);

  a_r4_len_never_grows: assert property (@(posedge clk) disable iff (!rstN)
    (devBusy && $past(devBusy)) |-> (devLen <= $past(devLen)));

  a_r7_irq_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  a_r9_kill_drops_active: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(status[ST_DEAD]) && !$past(ctrlWe)) |-> !status[ST_ACTIVE]);
endmodule

bind dma_seq_top dma_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .status(status), .memReq(memReq),
  .devStart(devStart), .devBusy(devBusy), .devLen(devLen), .irq(irq)
);

// File: tb/test_dma_seq_top.sv
`timescale 1ns/1ps
module test_dma_seq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0, ptrWe = 1'b0;
  logic [7:0]  ctrlMask = '0, ctrlVal = '0;
  logic [31:0] ptrVal = '0;
  logic [7:0]  status;
  logic [31:0] cmdPtr, memAddr, memWdata, memRdata, devAddr;
  logic        memReq, memWe, memAck;
  logic        devStart, devBusy, devIsOut, devIsLast, devChunk, devDone, irq;
  logic [15:0] devLen, devChunkLen;

  dma_seq_top i_dma_seq_top (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlMask(ctrlMask), .ctrlVal(ctrlVal),
    .ptrWe(ptrWe), .ptrVal(ptrVal), .status(status), .cmdPtr(cmdPtr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .devStart(devStart), .devBusy(devBusy),
    .devIsOut(devIsOut), .devIsLast(devIsLast), .devAddr(devAddr), .devLen(devLen),
    .devChunk(devChunk), .devChunkLen(devChunkLen), .devDone(devDone), .irq(irq)
  );

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  int irqCount = 0, startCount = 0, wrSeen = 0, busyMemReq = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: one outstanding request, acknowledged one cycle later
  logic [31:0] mem [512];
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRdata <= '0;
    end else begin
      memAck   <= memReq && !memAck;
      memRdata <= mem[memAddr[10:2]];
      if (memReq && memWe && !memAck) mem[memAddr[10:2]] <= memWdata;
    end
  end

  // scoreboard of expected memory writes
  typedef struct { logic [31:0] a; logic [31:0] d; string tag; } wr_t;
  wr_t expQ[$];
  task automatic expectWrite(input logic [31:0] a, input logic [31:0] d, input string tag);
    wr_t e;
    e.a = a; e.d = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (irq) irqCount++;
      if (devBusy && memReq) busyMemReq++;
      if (memReq && memWe && !memAck) begin
        wrSeen++;
        if (expQ.size() == 0) begin
          check("R9 unexpected write addr", memAddr, 32'hFFFF_FFFF);
        end else begin
          wr_t e;
          e = expQ.pop_front();
          check({e.tag, " write addr"}, memAddr, e.a);
          check({e.tag, " write data"}, memWdata, e.d);
        end
      end
    end
  end

  // device model driven by the plan set up before each chain
  int unsigned chunkPlan[$];
  logic [31:0] xpAddr;
  logic [15:0] xpLen;
  logic        xpOut, xpLast;
  initial begin : devModel
    logic [31:0] ea;
    logic [15:0] el;
    devChunk = 1'b0; devChunkLen = '0; devDone = 1'b0;
    forever begin
      @(negedge clk);
      if (devStart) begin
        startCount++;
        check("R3 direction", devIsOut, xpOut);
        check("R3 last flag", devIsLast, xpLast);
        @(negedge clk);
        check("R3 start addr", devAddr, xpAddr);
        check("R3 start len", devLen, xpLen);
        ea = xpAddr; el = xpLen;
        foreach (chunkPlan[i]) begin
          devChunk = 1'b1; devChunkLen = 16'(chunkPlan[i]);
          @(negedge clk);
          devChunk = 1'b0;
          ea = ea + chunkPlan[i];
          el = (chunkPlan[i] >= el) ? 16'd0 : el - 16'(chunkPlan[i]);
          check("R4 chunk addr", devAddr, ea);
          check("R4 chunk len", devLen, el);
        end
        check("R3 busy until done", devBusy, 1'b1);
        devDone = 1'b1;
        @(negedge clk);
        devDone = 1'b0;
      end
    end
  end

  function automatic logic [31:0] mkCmd(input logic [3:0] op, input logic [2:0] key,
      input logic [1:0] intS, input logic [1:0] brS, input logic [1:0] waitS, input logic [15:0] req);
    return {req, op, 1'b0, key, 2'b00, intS, brS, waitS};
  endfunction

  task automatic putDesc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
    mem[a[10:2]] = w0; mem[a[10:2] + 1] = w1; mem[a[10:2] + 2] = w2;
  endtask

  task automatic swWrite(input logic [7:0] m, input logic [7:0] v);
    ctrlWe = 1'b1; ctrlMask = m; ctrlVal = v;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic setPtr(input logic [31:0] a);
    ptrWe = 1'b1; ptrVal = a;
    @(negedge clk);
    ptrWe = 1'b0;
  endtask

  task automatic waitStopped(input string tag);
    int n = 0;
    while (status[1] && n < 400) begin
      @(negedge clk);
      n++;
    end
    check({tag, " chain ended"}, status[1], 1'b0);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  localparam logic [1:0] NEV = 2'd0, IFT = 2'd1, IFF = 2'd2, ALW = 2'd3;

  initial begin : main
    int w0, s0;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status", status, 8'h00);
    check("R1 cmdPtr", cmdPtr, 32'h0);
    check("R1 memReq", memReq, 1'b0);
    check("R1 devBusy", devBusy, 1'b0);
    check("R1 irq", irq, 1'b0);

    // Chain A: output-last with short residual, then stop
    putDesc(32'h000, mkCmd(4'd1, 3'd0, ALW, NEV, NEV, 16'd100), 32'h400, 32'h0);
    putDesc(32'h010, mkCmd(4'd7, 3'd0, NEV, NEV, NEV, 16'd0), 32'h0, 32'h0);
    chunkPlan = '{40, 30};
    xpAddr = 32'h400; xpLen = 16'd100; xpOut = 1'b1; xpLast = 1'b1;
    expectWrite(32'h00C, {8'h00, 8'h03, 16'd30}, "R5");
    setPtr(32'h000);
    swWrite(8'h03, 8'h03);
    check("R2 idle one cycle", memReq, 1'b0);
    @(negedge clk);
    check("R2 fetch starts", memReq, 1'b1);
    check("R2 fetch addr", memAddr, 32'h000);
    waitStopped("R10");
    check("R10 stop keeps ptr", cmdPtr, 32'h010);
    check("R10 status after stop", status, 8'h01);
    check("R7 irq always", irqCount, 1);

    // Chain B: input with overshooting chunk and flush, branch always, no-op branch if clear
    putDesc(32'h020, mkCmd(4'd2, 3'd2, IFT, ALW, NEV, 16'd50), 32'h500, 32'h040);
    putDesc(32'h040, mkCmd(4'd6, 3'd4, ALW, IFF, NEV, 16'd0), 32'h0, 32'h060);
    putDesc(32'h060, mkCmd(4'd7, 3'd0, NEV, NEV, NEV, 16'd0), 32'h0, 32'h0);
    chunkPlan = '{64};
    xpAddr = 32'h500; xpLen = 16'd50; xpOut = 1'b0; xpLast = 1'b0;
    expectWrite(32'h02C, {8'h00, 8'h0B, 16'd0}, "R5 flush seen");
    expectWrite(32'h04C, {8'h00, 8'h03, 16'd0}, "R13 nop flush cleared");
    setPtr(32'h020);
    swWrite(8'h0F, 8'h0B);
    waitStopped("R8");
    check("R8 branch target", cmdPtr, 32'h060);
    check("R7 irq if-set with flag clear", irqCount, 2);
    check("R13 nop no device start", startCount, 2);

    // Chain C: wait while flag set
    putDesc(32'h080, mkCmd(4'd0, 3'd1, NEV, NEV, IFT, 16'd8), 32'h600, 32'h0);
    putDesc(32'h090, mkCmd(4'd7, 3'd0, NEV, NEV, NEV, 16'd0), 32'h0, 32'h0);
    chunkPlan = '{8};
    xpAddr = 32'h600; xpLen = 16'd8; xpOut = 1'b1; xpLast = 1'b0;
    setPtr(32'h080);
    w0 = wrSeen;
    swWrite(8'h13, 8'h13);
    repeat (40) @(negedge clk);
    check("R6 no writeback while waiting", wrSeen, w0);
    check("R6 device released", devBusy, 1'b0);
    check("R6 pointer held", cmdPtr, 32'h080);
    check("R6 still active", status[1], 1'b1);
    expectWrite(32'h08C, {8'h00, 8'h03, 16'd0}, "R6");
    swWrite(8'h10, 8'h00);
    waitStopped("R6");
    check("R6 pointer after release", cmdPtr, 32'h090);
    check("R7 irq never", irqCount, 2);

    // Chain D: load then store
    mem[32'h700 >> 2] = 32'hCAFE_F00D;
    putDesc(32'h0A0, mkCmd(4'd5, 3'd6, NEV, ALW, NEV, 16'd4), 32'h700, 32'h1F0);
    putDesc(32'h0B0, mkCmd(4'd4, 3'd6, NEV, NEV, NEV, 16'd4), 32'h710, 32'h1234_5678);
    putDesc(32'h0C0, mkCmd(4'd7, 3'd0, NEV, NEV, NEV, 16'd0), 32'h0, 32'h0);
    expectWrite(32'h0A8, 32'hCAFE_F00D, "R11");
    expectWrite(32'h0AC, {8'h00, 8'h03, 16'd0}, "R11");
    expectWrite(32'h710, 32'h1234_5678, "R12");
    expectWrite(32'h0BC, {8'h00, 8'h03, 16'd0}, "R12");
    setPtr(32'h0A0);
    swWrite(8'h03, 8'h03);
    waitStopped("R11");
    check("R11 advance ignores branch", cmdPtr, 32'h0C0);
    check("R12 stored word", mem[32'h710 >> 2], 32'h1234_5678);

    // Chain E: kills
    putDesc(32'h0D0, mkCmd(4'd0, 3'd0, ALW, NEV, NEV, 16'd8), 32'h0, 32'h0);
    putDesc(32'h0E0, mkCmd(4'd3, 3'd4, ALW, NEV, NEV, 16'd8), 32'h500, 32'h0);
    putDesc(32'h0F0, mkCmd(4'd5, 3'd0, ALW, NEV, NEV, 16'd4), 32'h700, 32'h0);
    s0 = startCount;
    w0 = wrSeen;
    setPtr(32'h0D0);
    swWrite(8'h03, 8'h03);
    waitStopped("R9 zero addr");
    check("R9 zero addr status", status, 8'h05);
    check("R9 zero addr ptr", cmdPtr, 32'h0D0);
    setPtr(32'h0E0);
    swWrite(8'h06, 8'h02);
    waitStopped("R9 key4");
    check("R9 key4 status", status, 8'h05);
    setPtr(32'h0F0);
    swWrite(8'h06, 8'h02);
    waitStopped("R9 load key");
    check("R9 load key status", status, 8'h05);
    check("R9 no device start", startCount, s0);
    check("R9 no writes", wrSeen, w0);
    check("R9 no irq", irqCount, 2);

    // Stop clears dead
    setPtr(32'h010);
    swWrite(8'h02, 8'h02);
    waitStopped("R10 dead");
    check("R10 dead cleared", status, 8'h01);
    check("R10 ptr unchanged", cmdPtr, 32'h010);

    check("R3 no mem while busy", busyMemReq, 0);
    check("R5 all writes seen", expQ.size(), 0);
    finishRun();
  end
endmodule